// File: doc/BRIEF.md
# Data-Memory Overlay Decoder with Composite Select

This block sits on the data-memory access path of a processor core. It looks at each access and decides where it goes. The lower 8K-word half of the data space is an overlay window, and a page register chooses what that window maps to. Page 0 keeps the window on chip. Page 1 or page 2 sends the access off chip and folds the page number into the top bit of the external address. Any other page value is rejected as invalid. Addresses in the upper half of the space always stay on chip. An access to on-chip memory finishes in one cycle, and the block reports that with a one-cycle done pulse.

The block also drives a composite chip select. It can stand in for any combination of the four individual memory strobes: program, data, byte and I/O. A mask register chooses which strobes take part, and software writes and reads that register through a plain register port. The composite strobe is active low and follows the chosen strobes combinationally, so it matches their timing exactly. An access flagged as invalid holds the composite select inactive. All control and status pins are plain level signals. The block has no data stream and no back-pressure: an access is accepted in the cycle its strobe is high.

Top module: `ovl_csel_top`

## Requirements
- R1: With `acc_req` high, `acc_addr[13]` equal to 0 and `ovl_page` equal to 0, the access is internal. In that case `acc_ext` is 0, `acc_bad` is 0 and `ext_addr` is 0.
- R2: With `acc_req` high, `acc_addr[13]` equal to 0 and `ovl_page` equal to 1, the access is external: `acc_ext` is 1 and `ext_addr` is `{1'b0, acc_addr[12:0]}`.
- R3: With `acc_req` high, `acc_addr[13]` equal to 0 and `ovl_page` equal to 2, the access is external: `acc_ext` is 1 and `ext_addr` is `{1'b1, acc_addr[12:0]}`.
- R4: With `acc_req` high, `acc_addr[13]` equal to 0 and `ovl_page` at 3 or above, `acc_bad` is 1 and `acc_ext` is 0. `csel_n` is held at 1 whatever the strobes are.
- R5: With `acc_req` high and `acc_addr[13]` equal to 1, the access is internal for every page value. `acc_ext` and `acc_bad` are 0, and `ext_addr` is 0.
- R6: In the same cycle, `csel_n` is 0 exactly when some bit i has both `sel_n[i]` equal to 0 and mask bit i equal to 1. The bit order is: bit 0 program, bit 1 data, bit 2 byte, bit 3 I/O.
- R7: After reset, `mask_rdata` reads 4'b1011. Every strobe is enabled except the byte strobe (bit 2).
- R8: When `mask_we` is high at a rising edge, `mask_wdata` is stored. From the next cycle it shows on `mask_rdata` and governs `csel_n`. When `mask_we` is low, the mask keeps its value.
- R9: `int_done` is high for exactly the one cycle after a rising edge at which an internal access (R1 or R5) was presented. After an external access, an invalid access or no access, it is low.
- R10: With `acc_req` low, `acc_ext` and `acc_bad` are 0 and `ext_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Data-memory access strobe |
| acc_addr | input | 14 | Data-memory word address |
| ovl_page | input | 4 | Overlay page register value |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 4 | Mask register write data |
| mask_rdata | output | 4 | Mask register read-back |
| sel_n | input | 4 | Individual strobes, active low (program, data, byte, I/O) |
| ext_addr | output | 14 | External address for overlay accesses |
| acc_ext | output | 1 | Access goes to external memory |
| acc_bad | output | 1 | Access uses an invalid overlay page |
| int_done | output | 1 | Internal access completed (one cycle later) |
| csel_n | output | 1 | Composite select, active low |

## Verification
The only state in the block is the mask register and the done flag. A corrupted mask bit shows up on `mask_rdata` one cycle after the bad write. It also shows on `csel_n` as soon as the matching strobe falls. A wrong page decode is visible in the same cycle on `acc_ext`, `acc_bad` and `ext_addr[13]`. A misclassified access also shows up one cycle later as a missing or spurious `int_done`. The bench sweeps every page value against addresses at both edges of both halves of the space. It also sweeps every mask against every strobe pattern, so each of these faults reaches a port within one cycle.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_INT  = 2'd1,
    ACC_EXT  = 2'd2,
    ACC_BAD  = 2'd3
  } acc_kind_e;

  localparam int unsigned PAGE_INT  = 0;
  localparam int unsigned PAGE_EXT0 = 1;
  localparam int unsigned PAGE_EXT1 = 2;
endpackage

// File: rtl/ovl_addr_dec.sv
module ovl_addr_dec
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [PAGE_W-1:0] ovl_page,
  output acc_kind_e         kind,
  output logic [ADDR_W-1:0] ext_addr
);
  localparam int WIN_BIT = ADDR_W - 1;
  localparam int LOW_W   = ADDR_W - 1;

  logic in_win;
  logic pg_int, pg_e0, pg_e1;

  assign in_win = ~acc_addr[WIN_BIT];
  assign pg_int = (ovl_page == PAGE_W'(PAGE_INT));
  assign pg_e0  = (ovl_page == PAGE_W'(PAGE_EXT0));
  assign pg_e1  = (ovl_page == PAGE_W'(PAGE_EXT1));

  always_comb begin
    kind = ACC_IDLE;
    if (acc_req) begin
      if (!in_win || pg_int) kind = ACC_INT;
      else if (pg_e0 || pg_e1) kind = ACC_EXT;
      else kind = ACC_BAD;
    end
  end

  always_comb begin
    ext_addr = '0;
    if (kind == ACC_EXT) ext_addr = {pg_e1, acc_addr[LOW_W-1:0]};
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> (ext_addr == '0)); // R10
  AST_UPPER_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_addr[WIN_BIT]) |-> (kind == ACC_INT)); // R5
  AST_EXT_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_EXT) |-> (ext_addr[WIN_BIT] == (ovl_page == PAGE_W'(2)))); // R3
  AST_EXT_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_EXT) |-> (ext_addr[LOW_W-1:0] == acc_addr[LOW_W-1:0])); // R2
  AST_INT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_INT) |-> (ext_addr == '0)); // R1
endmodule

// File: rtl/csel_mask_reg.sv
module csel_mask_reg #(
  parameter int          SEL_N    = 4,
  parameter logic [SEL_N-1:0] RST_MASK = 4'b1011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_N-1:0] wdata,
  output logic [SEL_N-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) mask <= RST_MASK;
    else if (we) mask <= wdata;
  end

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mask == $past(wdata))); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask)); // R8
endmodule

// File: rtl/csel_combiner.sv
module csel_combiner #(
  parameter int SEL_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_N-1:0] sel_n,
  input  logic [SEL_N-1:0] mask,
  input  logic             block,
  output logic             csel_n
);
  logic [SEL_N-1:0] hit;

  for (genvar i = 0; i < SEL_N; i++) begin : g_hit
    assign hit[i] = ~sel_n[i] & mask[i];
  end

  assign csel_n = block | ~(|hit);

  AST_BLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> csel_n); // R4
  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (&sel_n) |-> csel_n); // R6
  AST_MASKED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask == '0) ) |-> csel_n); // R6
endmodule

// File: rtl/ovl_csel_top.sv
module ovl_csel_top
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 4,
  parameter int SEL_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [PAGE_W-1:0] ovl_page,
  input  logic              mask_we,
  input  logic [SEL_N-1:0]  mask_wdata,
  output logic [SEL_N-1:0]  mask_rdata,
  input  logic [SEL_N-1:0]  sel_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              acc_ext,
  output logic              acc_bad,
  output logic              int_done,
  output logic              csel_n
);
  acc_kind_e        kind;
  logic [SEL_N-1:0] mask_q;
  logic             done_q;

  ovl_addr_dec #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
    .ovl_page(ovl_page), .kind(kind), .ext_addr(ext_addr)
  );

  csel_mask_reg #(.SEL_N(SEL_N)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(mask_wdata), .mask(mask_q)
  );

  csel_combiner #(.SEL_N(SEL_N)) u_comb (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .mask(mask_q),
    .block(acc_bad), .csel_n(csel_n)
  );

  assign acc_ext    = (kind == ACC_EXT);
  assign acc_bad    = (kind == ACC_BAD);
  assign mask_rdata = mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= (kind == ACC_INT);
  end
  assign int_done = done_q;

  AST_EXT_BAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ext && acc_bad)); // R4
  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> (!acc_ext && !acc_bad)); // R10
  AST_DONE_AFTER_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_ext && !acc_bad) |=> int_done); // R9
  AST_NO_DONE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ext || acc_bad || !acc_req) |=> !int_done); // R9
endmodule

// File: tb/ovl_csel_top_tb.sv
`timescale 1ns/1ps
module ovl_csel_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_req = 1'b0;
  logic [13:0] acc_addr = '0;
  logic [3:0]  ovl_page = '0;
  logic        mask_we = 1'b0;
  logic [3:0]  mask_wdata = '0;
  logic [3:0]  mask_rdata;
  logic [3:0]  sel_n = 4'hF;
  logic [13:0] ext_addr;
  logic        acc_ext, acc_bad, int_done, csel_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  ovl_csel_top u_dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
    .ovl_page(ovl_page), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .mask_rdata(mask_rdata), .sel_n(sel_n), .ext_addr(ext_addr),
    .acc_ext(acc_ext), .acc_bad(acc_bad), .int_done(int_done), .csel_n(csel_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_for(input bit r, input logic [13:0] a, input logic [3:0] p);
    if (!r) return "R10";
    if (a[13]) return "R5";
    case (p)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin : watchdog
    #500000;
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [13:0] addrs [6];
    addrs[0] = 14'h0000; addrs[1] = 14'h0001; addrs[2] = 14'h0AAA;
    addrs[3] = 14'h1FFF; addrs[4] = 14'h2000; addrs[5] = 14'h3FFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R7 reset mask", 32'(mask_rdata), 32'hB);
    chk("R9 reset done", 32'(int_done), 0);

    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < 16; p++) begin
        for (int ai = 0; ai < 6; ai++) begin
          logic [13:0] a;
          bit eint, eext, ebad;
          logic [13:0] eaddr;
          a = addrs[ai];
          @(negedge clk);
          acc_req = r[0]; acc_addr = a; ovl_page = 4'(p); sel_n = 4'hF;
          eint = r[0] && (a[13] || p == 0);
          eext = r[0] && !a[13] && (p == 1 || p == 2);
          ebad = r[0] && !a[13] && p > 2;
          eaddr = eext ? {p == 2 ? 1'b1 : 1'b0, a[12:0]} : 14'h0;
          #1;
          chk(tag_for(r[0], a, 4'(p)), 32'(acc_ext), 32'(eext));
          chk(tag_for(r[0], a, 4'(p)), 32'(acc_bad), 32'(ebad));
          chk(tag_for(r[0], a, 4'(p)), 32'(ext_addr), 32'(eaddr));
          sel_n = 4'h0;
          #0.5;
          chk(ebad ? "R4 block" : "R6 reset mask", 32'(csel_n), ebad ? 1 : 0);
          @(posedge clk); #1;
          chk("R9 done", 32'(int_done), 32'(eint));
        end
      end
    end

    @(negedge clk); acc_req = 1'b0; sel_n = 4'hF;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk); mask_we = 1'b1; mask_wdata = 4'(m);
      @(negedge clk); mask_we = 1'b0; mask_wdata = ~4'(m);
      #1;
      chk("R8 readback", 32'(mask_rdata), 32'(m));
      for (int s = 0; s < 16; s++) begin
        bit exp_n;
        sel_n = 4'(s);
        exp_n = ((~4'(s) & 4'(m)) == 4'h0);
        #0.1;
        chk("R6 composite", 32'(csel_n), 32'(exp_n));
      end
      sel_n = 4'h0; acc_req = 1'b1; acc_addr = 14'h0100; ovl_page = 4'd3;
      #0.1;
      chk("R4 bad blocks csel", 32'(csel_n), 1);
      acc_req = 1'b0; sel_n = 4'hF;
      @(negedge clk); #1;
      chk("R8 hold", 32'(mask_rdata), 32'(m));
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule